// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog timer with one 32-bit control word on a simple register bus. The count input is a tick enable. A fixed divide-by-32 prescaler divides it, and a main counter then counts up to a terminal value of two raised to a 5-bit scale field. When the terminal value is reached, the block emits a one-cycle reset request and sets a sticky timeout flag in a separate status word. While still enabled, it then starts counting again from zero.

Software keeps the timer from expiring in one way only. It writes a 16-bit magic key of 0x5743 as a half-word into the upper half of the control word. The bus also offers set and clear alias addresses so that control bits can be changed atomically. The cycle that follows a disable is a quiet cycle, and the block drops any write that lands in it.

Top module: `keyclr_wdt`

## Requirements
- R1: After a synchronous reset, the control word (address 0) and the status word (address 3) both read zero, and `rst_req` is low.
- R2: A write to address 0 replaces the control bits in the bytes whose `bus_be` bit is set. The stored bits are: enable at bit 15, scale at bits 12:8, clock select at bits 7:6 and window flag at bit 0. All other bits read as zero. Addresses 0, 1 and 2 all read the control word.
- R3: A write to address 1 (set alias) ORs the written data, masked by the byte enables, into the control word.
- R4: A write to address 2 (clear alias) clears each control bit that is written as one in an enabled byte.
- R5: With the enable set and the scale field at S, `rst_req` rises after exactly 32·2^S edges at which `tick_en` was high. Edges with `tick_en` low are not counted.
- R6: `rst_req` is high for one cycle. While enabled, counting restarts from zero, so the next timeout again needs 32·2^S ticks.
- R7: A write to address 0 with `bus_be` = 4'b1100 and data bits 31:16 = 0x5743 clears the prescaler and the counter. A full period follows from that write.
- R8: A key half-word with any other value, or a full-word write (`bus_be` = 4'b1111) that carries 0x5743 in bits 31:16, leaves the count running. It only updates the control fields.
- R9: A timeout sets bit 4 of the status word. Writes to address 3 leave that bit unchanged. Only writing a one to bit 4 at address 4 (status clear alias) clears it.
- R10: While the enable is low, the prescaler and counter stay at zero and no `rst_req` is produced. A later enable starts a full period.
- R11: A write in the cycle that directly follows the one in which the enable went from 1 to 0 is ignored. A write one cycle later takes effect.
- R12: The window flag and the clock select field read back as written and have no effect on the timeout period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable fed to the prescaler |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | 0 control, 1 control set, 2 control clear, 3 status, 4 status clear |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The prescaler and counter cannot be read, so a wrong count shows up only as a timeout that comes early or late. The bench measures the number of ticks up to `rst_req` to the exact edge. A key that clears when it should not, or fails to clear when it should, changes that figure by the number of ticks already counted, here 50 of 64, within one period. A blanking or alias fault shows up in the control readback straight after the write, and a broken sticky flag shows up at the next status read.

// File: rtl/keyclr_wdt_pkg.sv
package keyclr_wdt_pkg;

    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int SCALE_W  = 5;
    localparam int CSEL_W   = 2;
    localparam int STAT_BIT = 4;
    localparam logic [15:0] CLEAR_KEY = 16'h5743;

    typedef enum logic [2:0] {
        A_CTRL     = 3'd0,
        A_CTRL_SET = 3'd1,
        A_CTRL_CLR = 3'd2,
        A_STAT     = 3'd3,
        A_STAT_CLR = 3'd4
    } wdt_addr_e;

    typedef struct packed {
        logic               on;
        logic [SCALE_W-1:0] scale;
        logic [CSEL_W-1:0]  csel;
        logic               win;
    } wdt_ctrl_t;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_9FC1;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input wdt_ctrl_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[15]    = c.on;
        w[12:8]  = c.scale;
        w[7:6]   = c.csel;
        w[0]     = c.win;
        return w;
    endfunction

    function automatic wdt_ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        wdt_ctrl_t c;
        c.on    = w[15];
        c.scale = w[12:8];
        c.csel  = w[7:6];
        c.win   = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/keyclr_wdt_regs.sv
module keyclr_wdt_regs
    import keyclr_wdt_pkg::*;
#(
    parameter logic [15:0] KEY = CLEAR_KEY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timeout,
    output wdt_ctrl_t         ctrl,
    output logic              key_hit,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [BE_W-1:0] UPPER_HALF = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};

    wdt_ctrl_t         ctrl_q;
    logic              on_prev_q;
    logic              flag_q;
    logic              quiet;
    logic              wr_ok;
    logic [DATA_W-1:0] cur_w;
    logic [DATA_W-1:0] fmask;
    logic [DATA_W-1:0] next_w;

    assign quiet = on_prev_q & ~ctrl_q.on;
    assign wr_ok = wr & ~quiet;
    assign cur_w = ctrl_to_word(ctrl_q);
    assign fmask = lane_mask(be) & CTRL_MASK;

    always_comb begin
        next_w = cur_w;
        unique case (addr)
            A_CTRL:     next_w = (cur_w & ~fmask) | (wdata & fmask);
            A_CTRL_SET: next_w = cur_w | (wdata & fmask);
            A_CTRL_CLR: next_w = cur_w & ~(wdata & fmask);
            default:    next_w = cur_w;
        endcase
    end

    assign key_hit = wr_ok && (addr == A_CTRL) && (be == UPPER_HALF)
                     && (wdata[DATA_W-1:DATA_W-16] == KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            on_prev_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            on_prev_q <= ctrl_q.on;
            if (wr_ok) begin
                ctrl_q <= word_to_ctrl(next_w);
            end
            if (timeout) begin
                flag_q <= 1'b1;
            end else if (wr_ok && addr == A_STAT_CLR && be[0] && wdata[STAT_BIT]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL || addr == A_CTRL_SET || addr == A_CTRL_CLR) begin
            rdata = cur_w;
        end else if (addr == A_STAT || addr == A_STAT_CLR) begin
            rdata[STAT_BIT] = flag_q;
        end
    end

    assign ctrl = ctrl_q;

    p_quiet_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        quiet |=> $stable(ctrl_q));

    p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
        timeout |=> flag_q);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(wr && addr == A_STAT_CLR)) |=> flag_q);

endmodule

// File: rtl/keyclr_wdt_counter.sv
module keyclr_wdt_counter
    import keyclr_wdt_pkg::*;
#(
    parameter int PRE_W = 5,
    parameter int SC_W  = SCALE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic            clr,
    input  logic [SC_W-1:0] scale,
    output logic            timeout
);

    localparam int CNT_W = 1 << SC_W;

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             pulse_q;

    assign last = ({{(CNT_W-1){1'b0}}, 1'b1} << scale) - {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || !en || clr) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (tick) begin
                if (&pre_q) begin
                    pre_q <= '0;
                    if (cnt_q >= last) begin
                        cnt_q   <= '0;
                        pulse_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    assign timeout = pulse_q;

    p_hold_off_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pre_q == '0 && cnt_q == '0 && !timeout));

    p_key_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pre_q == '0 && cnt_q == '0));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);

    p_pulse_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        timeout |-> $past(en));

endmodule

// File: rtl/keyclr_wdt.sv
module keyclr_wdt
    import keyclr_wdt_pkg::*;
#(
    parameter int          PRESCALE_LOG2 = 5,
    parameter logic [15:0] KEY           = CLEAR_KEY
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_req
);

    wdt_ctrl_t ctrl;
    logic      key_hit;
    logic      timeout;

    keyclr_wdt_regs #(.KEY(KEY)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .be      (bus_be),
        .wdata   (bus_wdata),
        .timeout (timeout),
        .ctrl    (ctrl),
        .key_hit (key_hit),
        .rdata   (bus_rdata)
    );

    keyclr_wdt_counter #(.PRE_W(PRESCALE_LOG2), .SC_W(SCALE_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.on),
        .tick    (tick_en),
        .clr     (key_hit),
        .scale   (ctrl.scale),
        .timeout (timeout)
    );

    assign rst_req = timeout;

endmodule

// File: tb/keyclr_wdt_test.sv
module keyclr_wdt_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [3:0]  bus_be = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    keyclr_wdt uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    always #10 clk = ~clk;

    localparam int NV = 8;
    localparam logic [2:0]  V_ADDR [NV] = '{3'd0, 3'd2, 3'd1, 3'd0, 3'd0, 3'd2, 3'd1, 3'd0};
    localparam logic [3:0]  V_BE   [NV] = '{4'hF, 4'hF, 4'h1, 4'h2, 4'h1, 4'hF, 4'hF, 4'hC};
    localparam logic [31:0] V_DATA [NV] = '{32'hFFFF_FFFF, 32'h0000_8001, 32'h0000_0001,
                                            32'h0000_0300, 32'h0000_0040, 32'hFFFF_FFFF,
                                            32'h0000_0A80, 32'h5743_FFFF};
    localparam logic [31:0] V_EXP  [NV] = '{32'h0000_9FC1, 32'h0000_1FC0, 32'h0000_1FC1,
                                            32'h0000_03C1, 32'h0000_0340, 32'h0000_0000,
                                            32'h0000_0A80, 32'h0000_0A80};
    localparam string       V_TAG  [NV] = '{"R2", "R4", "R3", "R2", "R12", "R4", "R3", "R8"};

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            report();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'd0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic run(input int n, output bit saw);
        saw = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (rst_req) saw = 1'b1;
        end
        tick_en = 1'b0;
    endtask

    task automatic measure(input bit gaps, output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            tick_en = gaps ? ((i % 2) == 0) : 1'b1;
            @(posedge clk);
            if (tick_en) n++;
            @(negedge clk);
            if (rst_req) break;
        end
        tick_en = 1'b0;
    endtask

    task automatic stop_timer();
        wr(3'd2, 4'hF, 32'h0000_FFFF);
        idle(1);
    endtask

    initial begin
        logic [31:0] d;
        int n;
        bit saw;

        idle(3);
        rst = 1'b0;
        @(negedge clk);

        rd(3'd0, d); check(d == 32'h0, "R1 ctrl", d, 32'h0);
        rd(3'd3, d); check(d == 32'h0, "R1 status", d, 32'h0);
        check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);

        for (int v = 0; v < NV; v++) begin
            wr(V_ADDR[v], V_BE[v], V_DATA[v]);
            idle(1);
            rd(3'd0, d);
            check(d == V_EXP[v], V_TAG[v], d, V_EXP[v]);
        end
        rd(3'd1, d); check(d == 32'h0000_0A80, "R2 set alias read", d, 32'h0000_0A80);
        stop_timer();

        // R5: scale 2 -> 128 ticks
        wr(3'd1, 4'hF, 32'h0000_8200);
        measure(1'b0, n); check(n == 128, "R5 period", n, 128);
        measure(1'b0, n); check(n == 128, "R6 restart period", n, 128);
        rd(3'd3, d); check(d == 32'h10, "R9 flag set", d, 32'h10);
        stop_timer();

        wr(3'd3, 4'hF, 32'h0000_0000); idle(1);
        rd(3'd3, d); check(d == 32'h10, "R9 plain write ignored", d, 32'h10);
        wr(3'd4, 4'h1, 32'h0000_0010); idle(1);
        rd(3'd3, d); check(d == 32'h0, "R9 clear alias", d, 32'h0);

        // R5 with gaps: scale 1 -> 64 counted ticks
        wr(3'd1, 4'hF, 32'h0000_8100);
        measure(1'b1, n); check(n == 64, "R5 gapped ticks", n, 64);
        stop_timer();

        // R7: good key restarts a full period
        wr(3'd1, 4'hF, 32'h0000_8100);
        run(50, saw);
        wr(3'd0, 4'hC, 32'h5743_0000);
        measure(1'b0, n); check(n == 64, "R7 key clears", n, 64);
        stop_timer();

        // R8: wrong key does not clear
        wr(3'd1, 4'hF, 32'h0000_8100);
        run(50, saw);
        wr(3'd0, 4'hC, 32'h1234_0000);
        measure(1'b0, n); check(n == 14, "R8 wrong key", n, 14);
        stop_timer();

        // R8: full-word write with key does not clear
        wr(3'd1, 4'hF, 32'h0000_8100);
        run(50, saw);
        wr(3'd0, 4'hF, 32'h5743_8100);
        measure(1'b0, n); check(n == 14, "R8 full word key", n, 14);
        stop_timer();

        // R10: disabled holds zero
        wr(3'd1, 4'hF, 32'h0000_8000);
        run(20, saw);
        wr(3'd2, 4'hF, 32'h0000_8000);
        run(100, saw);
        check(saw == 1'b0, "R10 no pulse while off", saw, 0);
        wr(3'd1, 4'hF, 32'h0000_8000);
        measure(1'b0, n); check(n == 32, "R10 fresh period", n, 32);
        stop_timer();

        // R11: write right after disable is dropped
        wr(3'd1, 4'hF, 32'h0000_8200);
        wr(3'd2, 4'hF, 32'h0000_8000);
        wr(3'd1, 4'hF, 32'h0000_1F00);
        rd(3'd0, d); check(d == 32'h0000_0200, "R11 quiet write dropped", d, 32'h0000_0200);
        wr(3'd1, 4'hF, 32'h0000_0100);
        rd(3'd0, d); check(d == 32'h0000_0300, "R11 later write taken", d, 32'h0000_0300);
        stop_timer();

        // R12: window flag and clock select do not change the period
        wr(3'd0, 4'hF, 32'h0000_80C1);
        measure(1'b0, n); check(n == 32, "R12 period unchanged", n, 32);
        stop_timer();

        report();
    end

endmodule